// File: doc/BRIEF.md
# Conditional-Window State Sequencer

This block holds the 8-bit state that controls a short run of conditionally executed instructions in a compressed instruction stream. The upper nibble of the state is the condition and the lower nibble is a window mask. When a window-opening instruction decodes, it loads a fresh state. Each retired instruction then pulses the advance strobe, and the block steps the state forward. For every instruction the block reports whether it sits inside a window, the condition in force, and whether that instruction should execute given the current N, Z, C and V flags.

A loaded state first goes into a pending register. The next advance moves it into the current state, which lets the opening instruction retire before its window takes effect. When nothing is pending, an advance shifts the mask left by one place. The bit pushed out of the mask becomes the low condition bit. When the mask runs empty, the whole state returns to zero. The state is also presented as a 6-bit upper slice and a 2-bit lower slice, ready for transfer to a status register.

Top module: `predblk_state_seq`

## Requirements
- R1: A synchronous active-high reset clears both the current and the pending state. After reset, state_o is 0, in_block_o is 0 and exec_o is 1, and an advance after reset leaves the state at 0 even if a value was staged before the reset.
- R2: A load without advance stages load_val in the pending register and leaves the current state unchanged. A staged value of zero does not displace the shifting of the current state.
- R3: An advance with no load in that cycle and a nonzero pending value copies the pending value into the current state and clears the pending register, so the following advance shifts instead of reloading.
- R4: With load and advance in the same cycle, the loaded value takes the place of the pending register, so a nonzero loaded value becomes the current state at that clock edge.
- R5: An advance with nothing pending and a nonzero current state shifts the mask (bits [3:0]) left by one. The old mask bit 3 goes into condition bit 0 (state bit 4), and state bits [7:5] are kept, provided the new mask is nonzero.
- R6: If the shifted mask is zero, the whole state becomes zero, including the condition field.
- R7: An advance with both pending and current state zero leaves the state at zero.
- R8: in_block_o is 1 exactly when state bits [3:0] are nonzero. act_cond_o is state bits [7:4] inside a window and 4'b1110 outside.
- R9: exec_o applies the condition to nzcv_i (N bit 3, Z bit 2, C bit 1, V bit 0). The codes are: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 and 1111 true. exec_o is 1 outside a window.
- R10: xfer_hi_o equals state bits [7:2] and xfer_lo_o equals state bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Stage load_val as the pending state |
| load_val | input | 8 | New state from a window-opening instruction |
| adv | input | 1 | One instruction retired; step the state |
| nzcv_i | input | 4 | Condition flags N,Z,C,V (bit 3 down to bit 0) |
| state_o | output | 8 | Current state |
| xfer_hi_o | output | 6 | Upper transfer slice, state [7:2] |
| xfer_lo_o | output | 2 | Lower transfer slice, state [1:0] |
| in_block_o | output | 1 | Inside a conditional window |
| act_cond_o | output | 4 | Condition in force |
| exec_o | output | 1 | Current instruction executes |

## Verification
A corrupted current state shows on state_o and on the transfer slices in the cycle after the faulty edge. A wrong refill bit or a mask that does not clear shows as a wrong state within one advance. It also shows as a flipped exec_o as soon as the flags separate the two conditions. A pending register that is not cleared only shows one advance later, when the state reloads instead of shifting. The bench therefore checks every advance against an arithmetic model. It also steps every 8-bit state to exhaustion and sweeps all 16 flag patterns for every state.

// File: rtl/predblk_pkg.sv
package predblk_pkg;
    localparam int PB_COND_W  = 4;
    localparam int PB_MASK_W  = 4;
    localparam int PB_STATE_W = PB_COND_W + PB_MASK_W;
    localparam int PB_HI_W    = PB_STATE_W - 2;

    localparam logic [PB_COND_W-1:0] PB_COND_ALWAYS = 4'b1110;

    typedef logic [PB_STATE_W-1:0] pb_state_t;

    typedef struct packed {
        pb_state_t cur;
        pb_state_t pend;
    } pb_regs_t;
endpackage

// File: rtl/predblk_shift.sv
module predblk_shift #(
    parameter int COND_W = 4,
    parameter int MASK_W = 4
) (
    input  logic [COND_W+MASK_W-1:0] state_i,
    output logic [COND_W+MASK_W-1:0] state_o
);
    localparam int SW = COND_W + MASK_W;

    logic [MASK_W-1:0] mask_now;
    logic [COND_W-1:0] cond_now;
    logic [MASK_W:0]   widened;
    logic [MASK_W-1:0] mask_next;
    logic              spill;

    always_comb begin
        mask_now  = state_i[MASK_W-1:0];
        cond_now  = state_i[SW-1:MASK_W];
        widened   = {mask_now, 1'b0};
        spill     = widened[MASK_W];
        mask_next = widened[MASK_W-1:0];
        if (mask_next == '0) begin
            state_o = '0;
        end else begin
            state_o = {cond_now[COND_W-1:1], spill, mask_next};
        end
    end
endmodule

// File: rtl/predblk_cond_eval.sv
module predblk_cond_eval (
    input  logic [3:0] code_i,
    input  logic [3:0] nzcv_i,
    output logic       pass_o
);
    logic n_f, z_f, c_f, v_f, base;

    always_comb begin
        n_f = nzcv_i[3];
        z_f = nzcv_i[2];
        c_f = nzcv_i[1];
        v_f = nzcv_i[0];
        unique case (code_i[3:1])
            3'b000:  base = z_f;
            3'b001:  base = c_f;
            3'b010:  base = n_f;
            3'b011:  base = v_f;
            3'b100:  base = c_f & ~z_f;
            3'b101:  base = (n_f == v_f);
            3'b110:  base = ~z_f & (n_f == v_f);
            default: base = 1'b1;
        endcase
        pass_o = (code_i[3:1] == 3'b111) ? 1'b1 : (base ^ code_i[0]);
    end
endmodule

// File: rtl/predblk_state_seq.sv
module predblk_state_seq
    import predblk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_en,
    input  logic [PB_STATE_W-1:0] load_val,
    input  logic                  adv,
    input  logic [3:0]            nzcv_i,
    output logic [PB_STATE_W-1:0] state_o,
    output logic [PB_HI_W-1:0]    xfer_hi_o,
    output logic [1:0]            xfer_lo_o,
    output logic                  in_block_o,
    output logic [PB_COND_W-1:0]  act_cond_o,
    output logic                  exec_o
);
    localparam int MW = PB_MASK_W;
    localparam int SW = PB_STATE_W;

    pb_regs_t  regs_q, regs_d;
    pb_state_t eff_pend;
    pb_state_t stepped;
    logic      cond_pass;

    predblk_shift #(.COND_W(PB_COND_W), .MASK_W(PB_MASK_W)) u_shift (
        .state_i (regs_q.cur),
        .state_o (stepped)
    );

    predblk_cond_eval u_eval (
        .code_i (regs_q.cur[SW-1:MW]),
        .nzcv_i (nzcv_i),
        .pass_o (cond_pass)
    );

    always_comb begin
        eff_pend    = load_en ? load_val : regs_q.pend;
        regs_d      = regs_q;
        regs_d.pend = eff_pend;
        if (adv) begin
            if (eff_pend != '0) begin
                regs_d.cur = eff_pend;
            end else if (regs_q.cur != '0) begin
                regs_d.cur = stepped;
            end
            regs_d.pend = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign state_o    = regs_q.cur;
    assign xfer_hi_o  = regs_q.cur[SW-1:2];
    assign xfer_lo_o  = regs_q.cur[1:0];
    assign in_block_o = |regs_q.cur[MW-1:0];
    assign act_cond_o = in_block_o ? regs_q.cur[SW-1:MW] : PB_COND_ALWAYS;
    assign exec_o     = in_block_o ? cond_pass : 1'b1;

    // R3
    pend_handover_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load_en && regs_q.pend != '0) |=>
        (regs_q.cur == $past(regs_q.pend) && regs_q.pend == '0));

    // R4
    load_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && load_en && load_val != '0) |=> (state_o == $past(load_val)));

    // R2
    no_adv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_o));

    // R5
    mask_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load_en && regs_q.pend == '0 && regs_q.cur[MW-2:0] != '0) |=>
        (state_o[MW-1:0] == {$past(state_o[MW-2:0]), 1'b0} &&
         state_o[MW] == $past(state_o[MW-1]) &&
         state_o[SW-1:MW+1] == $past(state_o[SW-1:MW+1])));

    // R6
    window_end_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load_en && regs_q.pend == '0 && regs_q.cur[MW-2:0] == '0) |=>
        (state_o == '0 && !in_block_o));

    // R9
    outside_exec_chk: assert property (@(posedge clk) disable iff (rst)
        !in_block_o |-> exec_o);
endmodule

// File: tb/predblk_state_seq_bench.sv
module predblk_state_seq_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [7:0] load_val;
    logic       adv;
    logic [3:0] nzcv_i;
    logic [7:0] state_o;
    logic [5:0] xfer_hi_o;
    logic [1:0] xfer_lo_o;
    logic       in_block_o;
    logic [3:0] act_cond_o;
    logic       exec_o;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;
    int m_cur  = 0;
    int m_pend = 0;

    predblk_state_seq u_predblk_state_seq (
        .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
        .adv(adv), .nzcv_i(nzcv_i), .state_o(state_o), .xfer_hi_o(xfer_hi_o),
        .xfer_lo_o(xfer_lo_o), .in_block_o(in_block_o),
        .act_cond_o(act_cond_o), .exec_o(exec_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles=%0d expected done", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int m_shift(input int s);
        int mask, nm, nb, cond;
        mask = s % 16;
        cond = s / 16;
        nm   = (mask * 2) % 16;
        nb   = (mask / 8) % 2;
        if (nm == 0) return 0;
        return ((cond / 2) * 2 + nb) * 16 + nm;
    endfunction

    function automatic int m_eval(input int code, input int f);
        bit n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (code)
            0:  return int'(z);
            1:  return int'(!z);
            2:  return int'(c);
            3:  return int'(!c);
            4:  return int'(n);
            5:  return int'(!n);
            6:  return int'(v);
            7:  return int'(!v);
            8:  return int'(c && !z);
            9:  return int'(!c || z);
            10: return int'(n == v);
            11: return int'(n != v);
            12: return int'(!z && (n == v));
            13: return int'(z || (n != v));
            default: return 1;
        endcase
    endfunction

    task automatic cyc(input bit l, input int v, input bit a);
        int ep;
        @(negedge clk);
        load_en = l; load_val = v[7:0]; adv = a;
        @(posedge clk);
        #1;
        load_en = 0; adv = 0;
        ep = l ? v : m_pend;
        if (a) begin
            if (ep != 0)         m_cur = ep;
            else if (m_cur != 0) m_cur = m_shift(m_cur);
            m_pend = 0;
        end else begin
            m_pend = ep;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1;
        rst = 0;
        m_cur = 0; m_pend = 0;
    endtask

    initial begin
        rst = 1; load_en = 0; load_val = 0; adv = 0; nzcv_i = 4'h0;
        do_reset();
        // R1 reset state
        chk("R1 state", int'(state_o), 0);
        chk("R1 in_block", int'(in_block_o), 0);
        chk("R1 exec", int'(exec_o), 1);

        // R2 staged value does not touch current state
        cyc(1, 8'h3C, 0);
        chk("R2 staged", int'(state_o), 0);
        // R3 handover then shift (pending cleared)
        cyc(0, 0, 1);
        chk("R3 handover", int'(state_o), 8'h3C);
        cyc(0, 0, 1);
        chk("R3 pend cleared, R5 shift", int'(state_o), 8'h38);
        cyc(0, 0, 1);
        chk("R6 window end", int'(state_o), 0);
        // R7 hold at zero
        cyc(0, 0, 1);
        chk("R7 hold", int'(state_o), 0);

        // R2 zero staged does not block shifting
        cyc(1, 8'hA6, 1);
        chk("R4 load+adv", int'(state_o), 8'hA6);
        cyc(1, 0, 0);
        chk("R2 hold on load", int'(state_o), 8'hA6);
        cyc(0, 0, 1);
        chk("R2 zero staged, shift", int'(state_o), m_cur);

        // R1 reset drops staged value
        cyc(1, 8'h5A, 0);
        do_reset();
        cyc(0, 0, 1);
        chk("R1 pend cleared by reset", int'(state_o), 0);

        // exhaustive sweep of all states
        for (int s = 0; s < 256; s++) begin
            do_reset();
            cyc(1, s, 1);
            if (s != 0) chk("R4 load+adv", int'(state_o), s);
            chk("R10 hi", int'(xfer_hi_o), s / 4);
            chk("R10 lo", int'(xfer_lo_o), s % 4);
            chk("R8 in_block", int'(in_block_o), int'((s % 16) != 0));
            chk("R8 act_cond", int'(act_cond_o), ((s % 16) != 0) ? s / 16 : 14);
            for (int f = 0; f < 16; f++) begin
                nzcv_i = f[3:0];
                #1;
                chk("R9 exec", int'(exec_o), ((s % 16) != 0) ? m_eval(s / 16, f) : 1);
            end
            for (int k = 0; k < 5; k++) begin
                int prev;
                prev = m_cur;
                cyc(0, 0, 1);
                if (prev == 0)            chk("R7 hold", int'(state_o), m_cur);
                else if (m_cur == 0)      chk("R6 clear", int'(state_o), m_cur);
                else                      chk("R5 shift", int'(state_o), m_cur);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule